// File: doc/BRIEF.md
# Rank Refresh and Wake-Up Scheduler

This block keeps one DRAM rank refreshed and decides when the rank may accept ordinary traffic. A free-running interval counter marks each point at which a refresh is owed. When the rank is awake and idle, the block sends the refresh command. If any bank is still open, it first sends a close-all-banks command and waits for the precharge time before the refresh. The refresh then occupies the rank for a fixed number of cycles.

The same block also tracks the rank's low-power state. The command scheduler can ask for a power-down or a self-refresh entry, and later for a wake-up. After a wake-up the rank stays unavailable for the exit latency, so the first activate can never share a cycle with the power-up. A single busy output tells the command scheduler to hold back reads, writes and activates. All timing values are parameters in clock cycles.

Top module: `rank_refresh_sched`

## Requirements
- R1: After reset the interval counter starts at zero. With the rank awake and idle, the first refresh command appears when T_REFI clock edges have passed since reset release. Later refresh points are spaced exactly T_REFI cycles apart, measured from the previous due point and not from the previous completion.
- R2: When a refresh is owed and no bit of `bank_open_i` is set, `ref_o` pulses with no close-all command before it.
- R3: When a refresh is owed and any bank is open, `pre_all_o` pulses first, and `ref_o` pulses exactly T_RP cycles later.
- R4: `rank_busy_o` is high from the cycle after a refresh falls due until T_RFC cycles after the `ref_o` cycle, so it is high for T_RFC+1 cycles counting the command cycle. It then drops, provided no other refresh is owed.
- R5: `pre_all_o` and `ref_o` are never high in the same cycle, and two `ref_o` pulses are always more than T_RFC cycles apart.
- R6: `pwr_state_o` uses 0 for awake, 1 for power-down with banks open, 2 for power-down with all banks closed and 3 for self-refresh. A sleep request is taken only while `rank_busy_o` is low. If `sleep_self_i` is low, the rank moves to code 1 when any bank is open and to code 2 otherwise. If `sleep_self_i` is high, the rank moves to code 3 only when every bank is closed; with a bank open the request is ignored. A request that is not taken leaves the state at 0.
- R7: A wake request in any of the codes 1 to 3 returns the state to 0 on the next edge. `rank_busy_o` is high in every low-power cycle and in the wake cycle. It stays high for T_XP-1 further cycles after the return to 0, so traffic may resume T_XP cycles after the wake cycle and never in it.
- R8: A wake request while the state is 0 leaves the state unchanged and raises `wake_err_o` for exactly one cycle, the cycle after the request.
- R9: A refresh that falls due during power-down (codes 1 and 2) is kept and is issued once the exit latency has elapsed. A refresh that falls due during self-refresh is dropped. While the rank sleeps, neither command output pulses.
- R10: During and right after reset, `pre_all_o`, `ref_o`, `rank_busy_o` and `wake_err_o` are low and `pwr_state_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bank_open_i | input | NUM_BANKS | One bit per bank, set while that bank holds an open row |
| sleep_req_i | input | 1 | Request to enter a low-power state |
| sleep_self_i | input | 1 | With a sleep request: 1 selects self-refresh, 0 selects power-down |
| wake_req_i | input | 1 | Request to leave the low-power state |
| pre_all_o | output | 1 | One-cycle close-all-banks command ahead of a refresh |
| ref_o | output | 1 | One-cycle refresh command |
| rank_busy_o | output | 1 | Rank unavailable to reads, writes and activates |
| pwr_state_o | output | 2 | Power state code (0 awake, 1/2 power-down, 3 self-refresh) |
| wake_err_o | output | 1 | One-cycle flag for a wake request made while awake |

## Verification
The bench aims at the cycle where each window ends. It measures the exact gap between the close-all and the refresh, and the exact length of the busy window after a refresh. If either timer is off by one, the refresh lands a cycle early or late, or traffic resumes while the rank is still refreshing. The wake-up exit is counted edge by edge. A design that frees the rank in the wake cycle itself, or one cycle before the exit latency ends, fails at that edge. Refresh points that fall during power-down and during self-refresh are both provoked. A design that forgets the owed refresh, or that replays one the device already performed in self-refresh, shows a missing or extra command after wake-up. Wrong-state wake requests and sleep requests that must be refused are checked through the state code on the next cycle.

// File: rtl/rfs_pkg.sv
// Shared types for the rank refresh scheduler.
package rfs_pkg;

    // Power state of the rank; the code values are visible on the top port.
    typedef enum logic [1:0] {
        PWR_AWAKE     = 2'd0,
        PWR_PD_OPEN   = 2'd1,
        PWR_PD_CLOSED = 2'd2,
        PWR_SELF_REF  = 2'd3
    } pwr_state_t;

    // Phase of the refresh sequence.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_CLOSE = 2'd1,
        SEQ_REF   = 2'd2
    } seq_state_t;

endpackage

// File: rtl/rfs_interval_timer.sv
// Free-running refresh interval counter.
// Raises due_o for one cycle every T_REFI cycles. It never waits for a
// refresh to finish, so late refreshes do not shift later due points.
// Assumes T_REFI >= 2.
module rfs_interval_timer #(
    parameter int T_REFI = 7800
) (
    input  logic clk,
    input  logic rst_n,
    output logic due_o
);
    localparam int CW = $clog2(T_REFI);
    localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);

    logic [CW-1:0] cnt_q;

    assign due_o = (cnt_q == LAST);

    // Count 0 .. T_REFI-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (due_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfs_ref_seq.sv
// Refresh sequencer for one rank.
// Holds a flag for each owed refresh. When the rank is ready it closes any
// open banks, waits T_RP cycles, issues the refresh, then waits T_RFC cycles.
// Refresh points that arrive during self-refresh are not recorded.
// Assumes T_RP >= 1 and T_RFC >= 1.
module rfs_ref_seq
    import rfs_pkg::*;
#(
    parameter int T_RFC = 260,
    parameter int T_RP  = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic due_i,
    input  logic self_ref_i,
    input  logic ready_i,
    input  logic any_open_i,
    output logic pre_all_o,
    output logic ref_o,
    output logic idle_o,
    output logic pend_o
);
    localparam int TMAX = (T_RFC > T_RP) ? T_RFC : T_RP;
    localparam int TW   = (TMAX > 1) ? $clog2(TMAX) : 1;
    localparam logic [TW-1:0] RP_LOAD  = TW'(T_RP - 1);
    localparam logic [TW-1:0] RFC_LOAD = TW'(T_RFC - 1);

    seq_state_t    st_q;
    logic [TW-1:0] tmr_q;
    logic          pend_q;
    logic          start;

    // A sequence may begin only from idle with a refresh owed and the rank ready.
    assign start     = (st_q == SEQ_IDLE) && pend_q && ready_i;
    assign pre_all_o = start && any_open_i;
    assign ref_o     = (start && !any_open_i) ||
                       ((st_q == SEQ_CLOSE) && (tmr_q == '0));
    assign idle_o    = (st_q == SEQ_IDLE);
    assign pend_o    = pend_q;

    // Owed-refresh flag: cleared by the command, set by a due point outside self-refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !ref_o) || (due_i && !self_ref_i);
        end
    end

    // Close, refresh and idle phases with their countdowns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SEQ_IDLE;
            tmr_q <= '0;
        end else begin
            case (st_q)
                SEQ_IDLE: begin
                    if (pre_all_o) begin
                        st_q  <= SEQ_CLOSE;
                        tmr_q <= RP_LOAD;
                    end else if (ref_o) begin
                        st_q  <= SEQ_REF;
                        tmr_q <= RFC_LOAD;
                    end
                end
                SEQ_CLOSE: begin
                    if (tmr_q == '0) begin
                        st_q  <= SEQ_REF;
                        tmr_q <= RFC_LOAD;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                SEQ_REF: begin
                    if (tmr_q == '0) begin
                        st_q <= SEQ_IDLE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                default: begin
                    st_q  <= SEQ_IDLE;
                    tmr_q <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/rfs_power_ctl.sv
// Low-power state tracker for one rank.
// Takes a sleep request only while the rank is quiet, picks the power-down
// flavour from the bank status, and on wake-up runs an exit countdown of
// T_XP cycles before the rank counts as ready. A wake request while awake
// is flagged for one cycle. Assumes T_XP >= 1.
module rfs_power_ctl
    import rfs_pkg::*;
#(
    parameter int T_XP = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req_i,
    input  logic       sleep_self_i,
    input  logic       wake_req_i,
    input  logic       any_open_i,
    input  logic       quiet_i,
    output pwr_state_t state_o,
    output logic       exit_done_o,
    output logic       wake_err_o
);
    localparam int XW = (T_XP > 1) ? $clog2(T_XP) : 1;
    localparam logic [XW-1:0] XP_LOAD = XW'(T_XP - 1);

    pwr_state_t    st_q;
    logic [XW-1:0] xcnt_q;
    logic          err_q;

    assign state_o     = st_q;
    assign exit_done_o = (xcnt_q == '0);
    assign wake_err_o  = err_q;

    // Power state transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PWR_AWAKE;
        end else if (st_q == PWR_AWAKE) begin
            if (sleep_req_i && quiet_i) begin
                if (sleep_self_i) begin
                    if (!any_open_i) begin
                        st_q <= PWR_SELF_REF;
                    end
                end else begin
                    st_q <= any_open_i ? PWR_PD_OPEN : PWR_PD_CLOSED;
                end
            end
        end else if (wake_req_i) begin
            st_q <= PWR_AWAKE;
        end
    end

    // Exit latency countdown, loaded on the wake edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcnt_q <= '0;
        end else if ((st_q != PWR_AWAKE) && wake_req_i) begin
            xcnt_q <= XP_LOAD;
        end else if (xcnt_q != '0) begin
            xcnt_q <= xcnt_q - 1'b1;
        end
    end

    // One-cycle flag for a wake request made while already awake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= (st_q == PWR_AWAKE) && wake_req_i;
        end
    end
endmodule

// File: rtl/rank_refresh_sched.sv
// Top of the rank refresh scheduler.
// Joins the interval timer, the refresh sequencer and the power tracker,
// and derives the single busy flag the command scheduler obeys. Address
// decode and data movement live elsewhere.
module rank_refresh_sched
    import rfs_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_REFI    = 7800,
    parameter int T_RFC     = 260,
    parameter int T_RP      = 14,
    parameter int T_XP      = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 sleep_req_i,
    input  logic                 sleep_self_i,
    input  logic                 wake_req_i,
    output logic                 pre_all_o,
    output logic                 ref_o,
    output logic                 rank_busy_o,
    output logic [1:0]           pwr_state_o,
    output logic                 wake_err_o
);
    logic       due;
    logic       any_open;
    logic       ready;
    logic       quiet;
    logic       seq_idle;
    logic       seq_pend;
    logic       exit_done;
    pwr_state_t pstate;

    assign any_open    = |bank_open_i;
    // Awake with the exit latency spent: refresh may start.
    assign ready       = (pstate == PWR_AWAKE) && exit_done;
    // Nothing owed and nothing running: traffic and sleep may proceed.
    assign quiet       = ready && seq_idle && !seq_pend;
    assign rank_busy_o = !quiet;
    assign pwr_state_o = pstate;

    rfs_interval_timer #(
        .T_REFI (T_REFI)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .due_o (due)
    );

    rfs_ref_seq #(
        .T_RFC (T_RFC),
        .T_RP  (T_RP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .due_i      (due),
        .self_ref_i (pstate == PWR_SELF_REF),
        .ready_i    (ready),
        .any_open_i (any_open),
        .pre_all_o  (pre_all_o),
        .ref_o      (ref_o),
        .idle_o     (seq_idle),
        .pend_o     (seq_pend)
    );

    rfs_power_ctl #(
        .T_XP (T_XP)
    ) u_pwr (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req_i  (sleep_req_i),
        .sleep_self_i (sleep_self_i),
        .wake_req_i   (wake_req_i),
        .any_open_i   (any_open),
        .quiet_i      (quiet),
        .state_o      (pstate),
        .exit_done_o  (exit_done),
        .wake_err_o   (wake_err_o)
    );
endmodule

// File: rtl/rank_refresh_sched_chk.sv
// Property checker for the rank refresh scheduler, bound to the top.
// Watches only top-level ports; spacing windows use local counters.
module rank_refresh_sched_chk #(
    parameter int NUM_BANKS = 8,
    parameter int T_RFC     = 260,
    parameter int T_RP      = 14
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_BANKS-1:0] bank_open_i,
    input logic                 wake_req_i,
    input logic                 pre_all_o,
    input logic                 ref_o,
    input logic                 rank_busy_o,
    input logic [1:0]           pwr_state_o,
    input logic                 wake_err_o
);
    int   since_ref;
    int   since_pre;
    logic pre_wait;

    // Cycles since the last refresh and since the last close-all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_ref <= T_RFC + 1;
            since_pre <= 0;
            pre_wait  <= 1'b0;
        end else begin
            if (ref_o) begin
                since_ref <= 1;
            end else if (since_ref <= T_RFC) begin
                since_ref <= since_ref + 1;
            end
            if (pre_all_o) begin
                pre_wait  <= 1'b1;
                since_pre <= 1;
            end else begin
                if (ref_o) begin
                    pre_wait <= 1'b0;
                end
                if (since_pre <= T_RP) begin
                    since_pre <= since_pre + 1;
                end
            end
        end
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_all_o && ref_o)); // R5
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ref_o |-> (since_ref > T_RFC)); // R5
    AST_CLOSE_TO_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_o && pre_wait) |-> (since_pre == T_RP)); // R3
    AST_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_all_o || ref_o) |-> rank_busy_o); // R4
    AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o != 2'd0) |-> (rank_busy_o && !ref_o && !pre_all_o)); // R7
    AST_WAKE_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wake_err_o |-> ($past(wake_req_i) && ($past(pwr_state_o) == 2'd0))); // R8
    AST_SELF_REF_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state_o == 2'd3) && ($past(pwr_state_o) == 2'd0)) |-> ($past(bank_open_i) == '0)); // R6
    AST_SLEEP_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state_o != 2'd0) && ($past(pwr_state_o) == 2'd0)) |-> !$past(rank_busy_o)); // R6
endmodule

bind rank_refresh_sched rank_refresh_sched_chk #(
    .NUM_BANKS (NUM_BANKS),
    .T_RFC     (T_RFC),
    .T_RP      (T_RP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bank_open_i (bank_open_i),
    .wake_req_i  (wake_req_i),
    .pre_all_o   (pre_all_o),
    .ref_o       (ref_o),
    .rank_busy_o (rank_busy_o),
    .pwr_state_o (pwr_state_o),
    .wake_err_o  (wake_err_o)
);

// File: tb/rank_refresh_sched_bench.sv
// Bench: behavioural cycle model compared on every cycle, plus directed
// checks on the timing windows.
module rank_refresh_sched_bench;
    localparam int CLK_P = 10;
    localparam int NB    = 4;
    localparam int REFI  = 40;
    localparam int RFC   = 6;
    localparam int RP    = 3;
    localparam int XP    = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] bank_open;
    logic          sleep_req, sleep_self, wake_req;
    logic          pre_all_o, ref_o, rank_busy_o, wake_err_o;
    logic [1:0]    pwr_state_o;

    int    n_chk = 0;
    int    n_err = 0;
    int    cyc   = 0;
    int    wd    = 0;
    bit    done  = 1'b0;
    string phase = "R10";

    always #(CLK_P/2) clk = ~clk;

    rank_refresh_sched #(
        .NUM_BANKS (NB),
        .T_REFI    (REFI),
        .T_RFC     (RFC),
        .T_RP      (RP),
        .T_XP      (XP)
    ) u_rank_refresh_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .bank_open_i  (bank_open),
        .sleep_req_i  (sleep_req),
        .sleep_self_i (sleep_self),
        .wake_req_i   (wake_req),
        .pre_all_o    (pre_all_o),
        .ref_o        (ref_o),
        .rank_busy_o  (rank_busy_o),
        .pwr_state_o  (pwr_state_o),
        .wake_err_o   (wake_err_o)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Reference model state, written behaviourally.
    int m_cnt, m_st, m_tmr, m_pwr, m_x;
    bit m_pend, m_err;

    logic e_any, e_ready, e_start, e_pre, e_ref, e_busy;
    assign e_any   = |bank_open;
    assign e_ready = (m_pwr == 0) && (m_x == 0);
    assign e_start = (m_st == 0) && m_pend && e_ready;
    assign e_pre   = e_start && e_any;
    assign e_ref   = (e_start && !e_any) || ((m_st == 1) && (m_tmr == 0));
    assign e_busy  = !(e_ready && (m_st == 0) && !m_pend);

    // Advance the model on each edge.
    always @(posedge clk) begin
        bit c_due, c_pre, c_ref, c_quiet, c_any;
        if (!rst_n) begin
            m_cnt = 0; m_st = 0; m_tmr = 0; m_pwr = 0; m_x = 0;
            m_pend = 1'b0; m_err = 1'b0; cyc = 0;
        end else begin
            cyc     = cyc + 1;
            c_due   = (m_cnt == REFI - 1);
            c_pre   = e_pre;
            c_ref   = e_ref;
            c_quiet = !e_busy;
            c_any   = e_any;
            m_err   = (m_pwr == 0) && wake_req;
            m_pend  = (m_pend && !c_ref) || (c_due && (m_pwr != 3));
            m_cnt   = c_due ? 0 : m_cnt + 1;
            case (m_st)
                0: if (c_pre) begin m_st = 1; m_tmr = RP - 1; end
                   else if (c_ref) begin m_st = 2; m_tmr = RFC - 1; end
                1: if (m_tmr == 0) begin m_st = 2; m_tmr = RFC - 1; end
                   else m_tmr = m_tmr - 1;
                default: if (m_tmr == 0) m_st = 0; else m_tmr = m_tmr - 1;
            endcase
            if (m_pwr == 0) begin
                if (m_x > 0) m_x = m_x - 1;
                if (sleep_req && c_quiet) begin
                    if (sleep_self) begin
                        if (!c_any) m_pwr = 3;
                    end else begin
                        m_pwr = c_any ? 1 : 2;
                    end
                end
            end else if (wake_req) begin
                m_pwr = 0;
                m_x   = XP - 1;
            end
        end
    end

    // Compare every output against the model a quarter period after the falling edge.
    always @(negedge clk) begin
        #(CLK_P/4);
        if (rst_n === 1'b1 && !done) begin
            chk(phase, "pre_all_o", int'(pre_all_o), int'(e_pre));
            chk(phase, "ref_o", int'(ref_o), int'(e_ref));
            chk(phase, "rank_busy_o", int'(rank_busy_o), int'(e_busy));
            chk(phase, "pwr_state_o", int'(pwr_state_o), m_pwr);
            chk(phase, "wake_err_o", int'(wake_err_o), int'(m_err));
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog %s actual=%0d expected=<20000", phase, wd);
            finish_run();
        end
    end

    task automatic sample();
        @(negedge clk);
        #(CLK_P/4);
    endtask

    task automatic wait_ref();
        sample();
        while (!ref_o) sample();
    endtask

    task automatic wait_free();
        while (rank_busy_o) sample();
    endtask

    initial begin
        int first_ref, second_ref, cp, cr, n, nref;
        bit saw_pre, got;
        bank_open = '0; sleep_req = 0; sleep_self = 0; wake_req = 0; rst_n = 0;
        repeat (3) @(negedge clk);
        #(CLK_P/4);
        // R10: values held during reset
        chk("R10", "pre_all_o in reset", int'(pre_all_o), 0);
        chk("R10", "ref_o in reset", int'(ref_o), 0);
        chk("R10", "rank_busy_o in reset", int'(rank_busy_o), 0);
        chk("R10", "pwr_state_o in reset", int'(pwr_state_o), 0);
        chk("R10", "wake_err_o in reset", int'(wake_err_o), 0);
        @(negedge clk);
        rst_n = 1;

        // R1 and R2: first refresh time, spacing, closed banks need no close-all
        phase = "R1";
        first_ref = -1; saw_pre = 0;
        for (int i = 0; i < 4 * REFI; i++) begin
            sample();
            if (pre_all_o) saw_pre = 1;
            if (ref_o) begin first_ref = cyc; break; end
        end
        chk("R1", "first refresh cycle", first_ref, REFI);
        chk("R2", "close-all before closed-bank refresh", int'(saw_pre), 0);
        // R4: busy spans the command cycle plus T_RFC
        phase = "R4";
        n = 1;
        for (int i = 0; i < 4 * RFC; i++) begin
            sample();
            if (!rank_busy_o) break;
            n++;
        end
        chk("R4", "busy cycles from refresh", n, RFC + 1);
        phase = "R1";
        wait_ref();
        second_ref = cyc;
        chk("R1", "refresh spacing", second_ref - first_ref, REFI);

        // R3: open bank forces close-all then refresh after T_RP
        phase = "R3";
        @(negedge clk);
        bank_open = 4'b0100;
        sample();
        while (!pre_all_o) sample();
        cp = cyc;
        @(negedge clk);
        bank_open = '0;
        #(CLK_P/4);
        while (!ref_o) sample();
        cr = cyc;
        chk("R3", "close-all to refresh gap", cr - cp, RP);
        wait_free();

        // R6: power-down with a bank open
        phase = "R6";
        @(negedge clk);
        bank_open = 4'b0001; sleep_req = 1; sleep_self = 0;
        @(negedge clk);
        sleep_req = 0;
        #(CLK_P/4);
        chk("R6", "power-down with open bank", int'(pwr_state_o), 1);
        repeat (3) sample();
        // R7: wake and exit latency
        phase = "R7";
        @(negedge clk);
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        #(CLK_P/4);
        chk("R7", "state after wake", int'(pwr_state_o), 0);
        n = 0;
        while (rank_busy_o && n < 20) begin n++; sample(); end
        chk("R7", "busy cycles after return to awake", n, XP - 1);
        // R8: wake while awake
        phase = "R8";
        @(negedge clk);
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        #(CLK_P/4);
        chk("R8", "wake_err_o after stray wake", int'(wake_err_o), 1);
        chk("R8", "state unchanged by stray wake", int'(pwr_state_o), 0);
        sample();
        chk("R8", "wake_err_o single cycle", int'(wake_err_o), 0);
        // R6: self-refresh refused with a bank open
        phase = "R6";
        @(negedge clk);
        sleep_req = 1; sleep_self = 1;
        @(negedge clk);
        sleep_req = 0; sleep_self = 0;
        #(CLK_P/4);
        chk("R6", "self-refresh refused with open bank", int'(pwr_state_o), 0);
        // R6: sleep refused while busy
        wait_ref();
        @(negedge clk);
        sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
        bank_open = '0;
        #(CLK_P/4);
        chk("R6", "sleep refused while busy", int'(pwr_state_o), 0);
        wait_free();

        // R9: refresh owed during power-down is kept
        phase = "R9";
        @(negedge clk);
        sleep_req = 1;
        @(negedge clk);
        sleep_req = 0;
        #(CLK_P/4);
        chk("R6", "power-down with banks closed", int'(pwr_state_o), 2);
        nref = 0;
        for (int i = 0; i < 2 * REFI; i++) begin
            sample();
            if (ref_o || pre_all_o) nref++;
        end
        chk("R9", "commands while powered down", nref, 0);
        @(negedge clk);
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        #(CLK_P/4);
        got = 0;
        for (int i = 0; i < XP + 4; i++) begin
            if (ref_o) got = 1;
            sample();
        end
        chk("R9", "owed refresh after power-down exit", int'(got), 1);
        wait_free();

        // R9: refresh points during self-refresh are dropped
        @(negedge clk);
        sleep_req = 1; sleep_self = 1;
        @(negedge clk);
        sleep_req = 0; sleep_self = 0;
        #(CLK_P/4);
        chk("R6", "self-refresh entry", int'(pwr_state_o), 3);
        repeat (2 * REFI) sample();
        while ((cyc % REFI) != 2) sample();
        @(negedge clk);
        wake_req = 1;
        @(negedge clk);
        wake_req = 0;
        #(CLK_P/4);
        nref = 0;
        for (int i = 0; i < XP + 5; i++) begin
            if (ref_o || pre_all_o) nref++;
            sample();
        end
        chk("R9", "commands after self-refresh exit", nref, 0);

        repeat (2) sample();
        finish_run();
    end
endmodule